// File: doc/BRIEF.md
# Checkpointable CAM Register Rename Table

This block renames destination registers through a content-addressed table with one entry per physical register. Each entry records the logical register it stands for and one of three states: active (the current mapping of its logical register), free (available for allocation), or future-free (superseded by a newer mapping but still readable by instructions in flight). One destination is renamed per cycle. The lowest-numbered free entry is taken, and the entry that held the previous mapping of the same logical register is demoted to future-free. Source operands are translated by matching a logical ID against the active entries.

Checkpoints are small because the table is content-addressed. A snapshot is only the active vector and the future-free vector, two bits per physical register. Logical IDs are never overwritten while a register is out of the free pool, so restoring the two vectors brings back the exact mapping. Free bits are rebuilt on restore as the NOR of the other two. Opening a checkpoint clears the live future-free bits, and those registers stay parked with no state bit set until a release mask returns them to the pool. The rename request is a valid/ready stream. `ren_ready` drops when no free entry exists, or when a restore or release occupies the table that cycle. A request held with `ren_valid` high while `ren_ready` is low is not performed, and it must stay asserted until it is accepted. Restore, release and checkpoint controls are plain single-cycle pulses.

Top module: `rat_cam`

## Requirements
- R1: After reset, entries 0..NUM_LOG-1 are active and map logical registers 0..NUM_LOG-1 one to one, all other entries are free, and no future-free bit is set.
- R2: No entry ever has more than one of its active, free and future-free bits set. An entry with none set is parked after a checkpoint opened and waits for release.
- R3: A rename handshake (`ren_valid` and `ren_ready` high at a clock edge) allocates the lowest-index free entry, reported on `ren_pid` in that cycle. From the next cycle that entry is active for `ren_lid`.
- R4: On a rename, the entry previously active for `ren_lid` is reported on `ren_old_pid` with `ren_old_hit`. It turns future-free and keeps its logical ID, so a later restore that reactivates it maps the same logical register again.
- R5: `src_pid` returns, combinationally, the index of the active entry whose logical ID equals `src_lid`, with `src_hit` high. The logical ID of an entry does not change while the entry is not free.
- R6: `snap_active` and `snap_ffree` show the registered active and future-free vectors, bit i for physical register i.
- R7: A `restore_valid` pulse loads the active and future-free vectors from `restore_active` and `restore_ffree` and sets each free bit to the NOR of the two. A restore overrides release, checkpoint opening and rename in the same cycle, and it holds `ren_ready` low.
- R8: A `ckpt_open` pulse clears every live future-free bit. A rename accepted in the same cycle still marks its previous entry future-free after the clear.
- R9: For each bit set in `release_mask`, the entry becomes free and loses its future-free bit in one cycle. While the mask is non-zero, `ren_ready` is low.
- R10: `stall` is high exactly when no entry is free. While it is high, `ren_ready` is low and the table does not change on a rename request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request valid |
| ren_ready | output | 1 | Rename request can be accepted this cycle |
| ren_lid | input | LW | Logical destination to rename |
| ren_pid | output | PW | Physical register allocated (lowest free index) |
| ren_old_pid | output | PW | Entry previously active for ren_lid |
| ren_old_hit | output | 1 | ren_old_pid is valid |
| stall | output | 1 | No free physical register |
| src_lid | input | LW | Logical source to look up |
| src_pid | output | PW | Active physical register for src_lid |
| src_hit | output | 1 | An active entry matches src_lid |
| snap_active | output | NUM_PHYS | Live active vector |
| snap_ffree | output | NUM_PHYS | Live future-free vector |
| ckpt_open | input | 1 | Clear live future-free bits |
| restore_valid | input | 1 | Load vectors from the restore inputs |
| restore_active | input | NUM_PHYS | Active vector to restore |
| restore_ffree | input | NUM_PHYS | Future-free vector to restore |
| release_mask | input | NUM_PHYS | Entries to return to the free pool |

## Verification
The assertions assume the surrounding logic gives the table only consistent inputs. A restored active vector and a restored future-free vector must not overlap. The restored active vector must hold one entry per logical register. A release mask must never include an entry that is currently active. One assertion checks the last of these at the port. The stimulus meets all three: it restores only vectors it captured earlier from the snapshot outputs or the reset mapping, and it releases only entries whose future-free bit it saw set, or saw cleared by a checkpoint opening.

// File: rtl/rat_pkg.sv
package rat_pkg;
  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_RESTORE = 2'd1,
    OP_RELEASE = 2'd2,
    OP_RENAME  = 2'd3
  } tbl_op_e;
endpackage

// File: rtl/rat_first_one.sv
module rat_first_one #(
  parameter int N = 16,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx,
  output logic         any
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/rat_cam_match.sv
module rat_cam_match #(
  parameter int N  = 16,
  parameter int KW = 3,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [KW-1:0] key,
  input  logic [KW-1:0] lid [N],
  input  logic [N-1:0]  act,
  output logic [W-1:0]  idx,
  output logic          hit
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = act[g] && (lid[g] == key);
  end

  rat_first_one #(.N(N)) u_enc (
    .req (match),
    .idx (idx),
    .any (hit)
  );
endmodule

// File: rtl/rat_cam.sv
module rat_cam
  import rat_pkg::*;
#(
  parameter int NUM_PHYS = 16,
  parameter int NUM_LOG  = 8,
  localparam int PW = $clog2(NUM_PHYS),
  localparam int LW = $clog2(NUM_LOG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ren_valid,
  output logic                ren_ready,
  input  logic [LW-1:0]       ren_lid,
  output logic [PW-1:0]       ren_pid,
  output logic [PW-1:0]       ren_old_pid,
  output logic                ren_old_hit,
  output logic                stall,
  input  logic [LW-1:0]       src_lid,
  output logic [PW-1:0]       src_pid,
  output logic                src_hit,
  output logic [NUM_PHYS-1:0] snap_active,
  output logic [NUM_PHYS-1:0] snap_ffree,
  input  logic                ckpt_open,
  input  logic                restore_valid,
  input  logic [NUM_PHYS-1:0] restore_active,
  input  logic [NUM_PHYS-1:0] restore_ffree,
  input  logic [NUM_PHYS-1:0] release_mask
);
  logic [NUM_PHYS-1:0] act_q, ffr_q, fre_q;
  logic [NUM_PHYS-1:0] act_d, ffr_d, fre_d;
  logic [LW-1:0]       lid_q [NUM_PHYS];
  logic [PW-1:0]       alloc_idx;
  logic                free_any;
  logic                ren_fire;
  tbl_op_e             op;

  rat_first_one #(.N(NUM_PHYS)) u_alloc (
    .req (fre_q),
    .idx (alloc_idx),
    .any (free_any)
  );

  rat_cam_match #(.N(NUM_PHYS), .KW(LW)) u_src (
    .key (src_lid),
    .lid (lid_q),
    .act (act_q),
    .idx (src_pid),
    .hit (src_hit)
  );

  rat_cam_match #(.N(NUM_PHYS), .KW(LW)) u_old (
    .key (ren_lid),
    .lid (lid_q),
    .act (act_q),
    .idx (ren_old_pid),
    .hit (ren_old_hit)
  );

  assign stall       = !free_any;
  assign ren_ready   = free_any && !restore_valid && (release_mask == '0);
  assign ren_fire    = ren_valid && ren_ready;
  assign ren_pid     = alloc_idx;
  assign snap_active = act_q;
  assign snap_ffree  = ffr_q;

  always_comb begin
    if (restore_valid)            op = OP_RESTORE;
    else if (release_mask != '0)  op = OP_RELEASE;
    else if (ren_fire)            op = OP_RENAME;
    else                          op = OP_HOLD;
  end

  always_comb begin
    act_d = act_q;
    ffr_d = ffr_q;
    fre_d = fre_q;
    if (op == OP_RESTORE) begin
      act_d = restore_active;
      ffr_d = restore_ffree;
      fre_d = ~(restore_active | restore_ffree);
    end else begin
      if (op == OP_RELEASE) begin
        fre_d = fre_d | release_mask;
        ffr_d = ffr_d & ~release_mask;
      end
      if (ckpt_open) ffr_d = '0;
      if (op == OP_RENAME) begin
        fre_d[alloc_idx] = 1'b0;
        act_d[alloc_idx] = 1'b1;
        if (ren_old_hit) begin
          act_d[ren_old_pid] = 1'b0;
          ffr_d[ren_old_pid] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) begin
        act_q[i] <= (i < NUM_LOG);
        fre_q[i] <= (i >= NUM_LOG);
        ffr_q[i] <= 1'b0;
        lid_q[i] <= (i < NUM_LOG) ? LW'(i) : '0;
      end
    end else begin
      act_q <= act_d;
      ffr_q <= ffr_d;
      fre_q <= fre_d;
      if (op == OP_RENAME) lid_q[alloc_idx] <= ren_lid;
    end
  end

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_chk
    a_r2_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({act_q[g], ffr_q[g], fre_q[g]}));
    a_r5_lid_held: assert property (@(posedge clk) disable iff (!rst_n)
      !fre_q[g] |=> $stable(lid_q[g]));
  end

  a_r3_alloc_active: assert property (@(posedge clk) disable iff (!rst_n)
    ren_fire |=> act_q[$past(alloc_idx)] && (lid_q[$past(alloc_idx)] == $past(ren_lid)));

  a_r4_old_retired: assert property (@(posedge clk) disable iff (!rst_n)
    ren_fire && ren_old_hit |=> ffr_q[$past(ren_old_pid)] && !act_q[$past(ren_old_pid)]);

  a_r7_restore_free: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |=> fre_q == ~($past(restore_active) | $past(restore_ffree)));

  a_r9_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (release_mask != '0) && !restore_valid |=> (fre_q & $past(release_mask)) == $past(release_mask));

  a_r9_release_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (release_mask != '0) && !restore_valid |-> (release_mask & act_q) == '0);

  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !ren_ready);
endmodule

// File: tb/rat_cam_test.sv
module rat_cam_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NL = 8;
  localparam int PW = $clog2(NP);
  localparam int LW = $clog2(NL);

  logic clk = 0, rst_n = 0;
  logic ren_valid = 0;
  logic ren_ready;
  logic [LW-1:0] ren_lid = '0;
  logic [PW-1:0] ren_pid, ren_old_pid;
  logic ren_old_hit, stall;
  logic [LW-1:0] src_lid = '0;
  logic [PW-1:0] src_pid;
  logic src_hit;
  logic [NP-1:0] snap_active, snap_ffree;
  logic ckpt_open = 0, restore_valid = 0;
  logic [NP-1:0] restore_active = '0, restore_ffree = '0, release_mask = '0;

  int checks = 0, errors = 0;
  int exp_pid[$];
  int exp_old[$];
  logic [NP-1:0] sv_act, sv_ffr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rat_cam #(.NUM_PHYS(NP), .NUM_LOG(NL)) uut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_lid(ren_lid), .ren_pid(ren_pid), .ren_old_pid(ren_old_pid),
    .ren_old_hit(ren_old_hit), .stall(stall), .src_lid(src_lid),
    .src_pid(src_pid), .src_hit(src_hit), .snap_active(snap_active),
    .snap_ffree(snap_ffree), .ckpt_open(ckpt_open),
    .restore_valid(restore_valid), .restore_active(restore_active),
    .restore_ffree(restore_ffree), .release_mask(release_mask)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every accepted rename
  always @(negedge clk) begin
    if (rst_n && ren_valid && ren_ready) begin
      checks++;
      if (exp_pid.size() == 0) begin
        errors++;
        $display("FAIL R10: actual=accepted expected=no rename");
      end else begin
        int ep, eo;
        ep = exp_pid.pop_front();
        eo = exp_old.pop_front();
        if (ren_pid !== PW'(ep) || ren_old_pid !== PW'(eo) || ren_old_hit !== 1'b1) begin
          errors++;
          $display("FAIL R3/R4: actual pid=%0d old=%0d hit=%0b expected pid=%0d old=%0d hit=1",
                   ren_pid, ren_old_pid, ren_old_hit, ep, eo);
        end
      end
    end
  end

  task automatic rename(int lid, int pid, int old, bit open = 0);
    exp_pid.push_back(pid);
    exp_old.push_back(old);
    ren_lid = LW'(lid);
    ren_valid = 1;
    ckpt_open = open;
    @(posedge clk); #1;
    ren_valid = 0;
    ckpt_open = 0;
  endtask

  task automatic lookup(string req, int lid, int pid);
    src_lid = LW'(lid);
    #1;
    chk(req, {src_hit, 8'(src_pid)}, {1'b1, 8'(pid)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #(CLK_PERIOD/2);
    // R1 reset
    chk("R1 active", snap_active, 16'h00FF);
    chk("R1 ffree", snap_ffree, 16'h0000);
    chk("R1 first free", ren_pid, 8);
    chk("R10 no stall", stall, 0);
    lookup("R1 map", 3, 3);
    @(posedge clk); #1;
    rename(3, 8, 3);
    rename(3, 9, 8);
    rename(5, 10, 5);
    #(CLK_PERIOD/2);
    chk("R6 active", snap_active, 16'h06D7);
    chk("R4 ffree", snap_ffree, 16'h0128);
    lookup("R5 lid3", 3, 9);
    lookup("R5 lid5", 5, 10);
    sv_act = snap_active; sv_ffr = snap_ffree;
    @(posedge clk); #1;
    ckpt_open = 1;
    @(posedge clk); #1;
    ckpt_open = 0;
    chk("R8 cleared", snap_ffree, 16'h0000);
    rename(0, 11, 0);
    chk("R8 new ffree", snap_ffree, 16'h0001);
    // release with a pending rename: ready must drop
    release_mask = 16'h0128; ren_valid = 1; ren_lid = 2;
    #(CLK_PERIOD/2);
    chk("R9 ready low", ren_ready, 0);
    @(posedge clk); #1;
    release_mask = '0; ren_valid = 0;
    chk("R9 lowest free", ren_pid, 3);
    chk("R9 ffree kept", snap_ffree, 16'h0001);
    // restore to saved snapshot, rename held off
    restore_valid = 1; restore_active = sv_act; restore_ffree = sv_ffr;
    ren_valid = 1; ren_lid = 4;
    #(CLK_PERIOD/2);
    chk("R7 ready low", ren_ready, 0);
    @(posedge clk); #1;
    restore_valid = 0; ren_valid = 0;
    chk("R7 active", snap_active, 16'h06D7);
    chk("R7 ffree", snap_ffree, 16'h0128);
    chk("R7 free nor", ren_pid, 11);
    lookup("R7 lid0", 0, 0);
    // restore reset mapping: demoted entries keep their IDs
    restore_valid = 1; restore_active = 16'h00FF; restore_ffree = '0;
    @(posedge clk); #1;
    restore_valid = 0;
    lookup("R4 lid kept 3", 3, 3);
    lookup("R4 lid kept 5", 5, 5);
    // exhaust the pool
    for (int k = 0; k < 8; k++) rename(1, 8 + k, (k == 0) ? 1 : 7 + k);
    chk("R10 stall", stall, 1);
    ren_valid = 1; ren_lid = 6;
    #(CLK_PERIOD/2);
    chk("R10 ready low", ren_ready, 0);
    @(posedge clk); #1;
    ren_valid = 0;
    chk("R10 table held", snap_active, 16'h80FD);
    chk("R10 ffree held", snap_ffree, 16'h7F02);
    release_mask = 16'h0002;
    @(posedge clk); #1;
    release_mask = '0;
    chk("R9 freed", {stall, 8'(ren_pid)}, {1'b0, 8'd1});
    rename(2, 1, 2, 1);
    chk("R8 open+rename ffree", snap_ffree, 16'h0004);
    chk("R3 active", snap_active, 16'h80FB);
    lookup("R3 lid2", 2, 1);
    chk("R3 scoreboard empty", exp_pid.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule